// File: doc/BRIEF.md
# Processor Slot Hotplug Event Register Bank

This block keeps two bits of state for each of a fixed number of processor slots: whether a processor occupies the slot, and whether the slot has an insert event that software has not yet handled. A plug strobe from the platform side names a slot and says whether the insertion happened at run time ("hot"). A hot insertion marks the slot pending and sends a one-cycle interrupt request.

Software reaches the state through a small byte-addressed register window. A 32-bit selector at offset 0 picks a slot. A flags byte at offset 4 shows that slot's presence and pending bits, and writing bit 1 of that byte acknowledges the event. A command byte at offset 5 accepts code 0, "find next pending slot". This code starts a circular search that begins at the selector and moves the selector to the first pending slot it finds. A 32-bit result register at offset 8 returns the selector. Software can therefore drain every pending event with a loop of search, read, acknowledge.

The search visits one slot per clock cycle. While it runs, the block holds `bus_ready` low, so no register access can see a half-updated selector.

Top module: `hotplug_evt_bank`

## Requirements
- R1: After reset no slot is present or pending, the selector and the stored command are 0, `evt_irq` and `scan_busy` are low and `bus_ready` is high.
- R2: A write to offset 0 stores all 32 bits of write data as the selector, whatever the value. While the stored command is 0, a read of offset 8 returns the selector.
- R3: A read of offset 4 returns bit 0 = presence and bit 1 = pending event of the selected slot, with bits 31:2 zero. It returns 0 when the selector is not below the slot count.
- R4: A write to offset 4 with bit 1 set clears the selected slot's pending bit. Bit 1 clear, bit 0 and a selector at or above the slot count have no effect.
- R5: A plug strobe always sets its slot's presence bit. With `plug_hot` high it also sets the pending bit, and `evt_irq` is high for exactly the one cycle after the strobe. With `plug_hot` low, `evt_irq` stays low.
- R6: Writing code 0 (bits 7:0) to offset 5 starts a search at the selector, or at slot 0 if the selector is out of range. The search steps upward and wraps after the last slot, and loads the first pending slot's index into the selector.
- R7: If no slot is pending, the search ends after visiting every slot once and leaves the selector unchanged.
- R8: `scan_busy` is high and `bus_ready` is low from the cycle after the command write. This lasts k+1 cycles when the hit is k steps from the start, and exactly slot-count cycles on a miss.
- R9: Command codes of 1 or more are ignored: the stored command keeps its value and no search starts.
- R10: Reads of offsets other than 0x4 and 0x8 (including the write-only 0x0 and 0x5) return 0. Writes to offsets other than 0x0, 0x4 and 0x5 change nothing.
- R11: If a hot plug and an acknowledge of the same slot fall in the same cycle, the slot is left pending.
- R12: An accepted read raises `rd_valid` in the next cycle, with its data on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plug_stb | input | 1 | Plug event strobe |
| plug_slot | input | SW | Slot index of the plug event |
| plug_hot | input | 1 | Plug happened at run time |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 32 | Write data, bytes at offsets 4 and 5 in bits 7:0 |
| bus_ready | output | 1 | Access accepted when high with bus_valid |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| evt_irq | output | 1 | One-cycle insert event interrupt request |
| scan_busy | output | 1 | Search in progress |

## Verification
The assertions assume that an access waits for `bus_ready` and that the plug strobe always names a slot inside the slot count, which its width guarantees for a power-of-two count. The stimulus keeps `plug_stb` low while a search runs. Under that condition the pending set stays fixed during a search, so the bench model can predict the hit slot and the busy length before the search starts. Random selector values include out-of-range and full 32-bit values, which exercise the zero-read and no-effect paths.

// File: rtl/hpreg_pkg.sv
package hpreg_pkg;
   localparam int unsigned ADDR_W   = 4;
   localparam logic [3:0]  OFS_SEL   = 4'h0;
   localparam logic [3:0]  OFS_FLAGS = 4'h4;
   localparam logic [3:0]  OFS_CMD   = 4'h5;
   localparam logic [3:0]  OFS_DATA  = 4'h8;
   localparam int unsigned NUM_CMDS = 1;

   typedef enum logic [7:0] {
      CMD_NEXT_PENDING = 8'd0
   } cmd_e;

   typedef struct packed {
      logic [29:0] zero;
      logic        pending;
      logic        present;
   } flags_t;
endpackage

// File: rtl/slot_state_bits.sv
module slot_state_bits #(
   parameter int unsigned NSLOT = 8,
   parameter int unsigned SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             plug_stb,
   input  logic [SW-1:0]    plug_slot,
   input  logic             plug_hot,
   input  logic             clr_en,
   input  logic [SW-1:0]    clr_slot,
   output logic [NSLOT-1:0] present,
   output logic [NSLOT-1:0] pending
);
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic hit_plug, hit_clr;
      assign hit_plug = plug_stb && (plug_slot == SW'(g));
      assign hit_clr  = clr_en && (clr_slot == SW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            present[g] <= 1'b0;
            pending[g] <= 1'b0;
         end else begin
            if (hit_plug) present[g] <= 1'b1;
            if (hit_plug && plug_hot) pending[g] <= 1'b1;
            else if (hit_clr)         pending[g] <= 1'b0;
         end
      end

      // R5 / R11: a hot plug leaves the slot pending even with a same-cycle clear
      p_hot_sets_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_plug && plug_hot) |=> (pending[g] && present[g]));

      // R4: a clear without a plug drops the pending bit
      p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_clr && !hit_plug) |=> !pending[g]);
   end
endmodule

// File: rtl/next_event_scan.sv
module next_event_scan #(
   parameter int unsigned NSLOT = 8,
   parameter int unsigned SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SW-1:0]    start_idx,
   input  logic [NSLOT-1:0] pending,
   output logic             busy,
   output logic             done,
   output logic             found,
   output logic [SW-1:0]    found_idx
);
   localparam int unsigned CW = $clog2(NSLOT + 1);

   if (NSLOT < 2) begin : g_bad_nslot
      $error("next_event_scan: NSLOT must be at least 2");
   end

   logic          busy_q;
   logic [SW-1:0] ptr_q, ptr_nxt;
   logic [CW-1:0] cnt_q;
   logic          hit, last;

   if ((1 << SW) == NSLOT) begin : g_wrap_pow2
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (ptr_q == SW'(NSLOT - 1)) ? '0 : ptr_q + 1'b1;
   end

   assign hit       = busy_q && pending[ptr_q];
   assign last      = (cnt_q == CW'(NSLOT - 1));
   assign done      = busy_q && (hit || last);
   assign found     = hit;
   assign found_idx = ptr_q;
   assign busy      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         ptr_q  <= start_idx;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (done) busy_q <= 1'b0;
         else begin
            ptr_q <= ptr_nxt;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // checker: length of the current busy run
   logic [CW:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= '0;
      else if (busy_q) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (run_len < (CW+1)'(NSLOT)));

   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);
endmodule

// File: rtl/hotplug_evt_bank.sv
module hotplug_evt_bank
   import hpreg_pkg::*;
#(
   parameter int unsigned NSLOT = 8,
   parameter int unsigned SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              plug_stb,
   input  logic [SW-1:0]     plug_slot,
   input  logic              plug_hot,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ready,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              evt_irq,
   output logic              scan_busy
);
   if (NSLOT < 2 || NSLOT > 256) begin : g_bad_nslot
      $error("hotplug_evt_bank: NSLOT out of range");
   end

   logic [31:0]      sel_q;
   logic [7:0]       cmd_q;
   logic [NSLOT-1:0] present, pending;
   logic             sel_ok;
   logic [SW-1:0]    sel_idx;
   logic             acc, wr_acc, rd_acc;
   logic             clr_en, cmd_ok, start;
   logic             scan_done, scan_found;
   logic [SW-1:0]    scan_idx;
   flags_t           flags_v;
   logic [31:0]      rd_mux;

   assign sel_ok  = (sel_q < 32'(NSLOT));
   assign sel_idx = sel_q[SW-1:0];

   assign bus_ready = !scan_busy;
   assign acc       = bus_valid && bus_ready;
   assign wr_acc    = acc && bus_write;
   assign rd_acc    = acc && !bus_write;

   assign clr_en = wr_acc && (bus_addr == OFS_FLAGS) && bus_wdata[1] && sel_ok;
   assign cmd_ok = (bus_wdata[7:0] < 8'(NUM_CMDS));
   assign start  = wr_acc && (bus_addr == OFS_CMD) && cmd_ok
                   && (bus_wdata[7:0] == 8'(CMD_NEXT_PENDING));

   slot_state_bits #(.NSLOT(NSLOT), .SW(SW)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .plug_stb (plug_stb),
      .plug_slot(plug_slot),
      .plug_hot (plug_hot),
      .clr_en   (clr_en),
      .clr_slot (sel_idx),
      .present  (present),
      .pending  (pending)
   );

   next_event_scan #(.NSLOT(NSLOT), .SW(SW)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_idx(sel_ok ? sel_idx : '0),
      .pending  (pending),
      .busy     (scan_busy),
      .done     (scan_done),
      .found    (scan_found),
      .found_idx(scan_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         cmd_q   <= 8'(CMD_NEXT_PENDING);
         evt_irq <= 1'b0;
      end else begin
         if (wr_acc && bus_addr == OFS_SEL) sel_q <= bus_wdata;
         else if (scan_done && scan_found)  sel_q <= 32'(scan_idx);
         if (wr_acc && bus_addr == OFS_CMD && cmd_ok) cmd_q <= bus_wdata[7:0];
         evt_irq <= plug_stb && plug_hot;
      end
   end

   always_comb begin
      flags_v         = '0;
      flags_v.present = sel_ok && present[sel_idx];
      flags_v.pending = sel_ok && pending[sel_idx];
      case (bus_addr)
         OFS_FLAGS: rd_mux = flags_v;
         OFS_DATA:  rd_mux = (cmd_q == 8'(CMD_NEXT_PENDING)) ? sel_q : '0;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_acc;
         if (rd_acc) rd_data <= rd_mux;
      end
   end

   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> !bus_ready);

   p_hit_loads_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && scan_found) |=> (sel_q == 32'($past(scan_idx)) && pending[sel_q[SW-1:0]]));

   p_miss_keeps_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !scan_found) |=> $stable(sel_q));

   p_bad_cmd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && bus_addr == OFS_CMD && !cmd_ok) |=> (!scan_busy && $stable(cmd_q)));

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && bus_addr != OFS_FLAGS && bus_addr != OFS_DATA) |=> (rd_valid && rd_data == '0));

   p_irq_after_hot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (plug_stb && plug_hot) |=> evt_irq);
endmodule

// File: tb/hotplug_evt_bank_bench.sv
module hotplug_evt_bank_bench;
   localparam int unsigned NS = 8;
   localparam int unsigned SW = 3;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic plug_stb = 0, plug_hot = 0;
   logic [SW-1:0] plug_slot = '0;
   logic bus_valid = 0, bus_write = 0;
   logic [3:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic bus_ready, rd_valid, evt_irq, scan_busy;
   logic [31:0] rd_data;

   int checks = 0, bad = 0;
   bit finished = 0;
   bit mpres [NS];
   bit mpend [NS];
   logic [31:0] msel;

   always #(CLK_PERIOD/2) clk = ~clk;

   hotplug_evt_bank #(.NSLOT(NS)) u_hotplug_evt_bank (
      .clk(clk), .rst_n(rst_n), .plug_stb(plug_stb), .plug_slot(plug_slot),
      .plug_hot(plug_hot), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .evt_irq(evt_irq), .scan_busy(scan_busy));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_flags();
      if (msel >= NS) return 32'd0;
      return {30'd0, mpend[msel[SW-1:0]], mpres[msel[SW-1:0]]};
   endfunction

   task automatic bus_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
      while (!bus_ready) @(negedge clk);
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = a;
      while (!bus_ready) @(negedge clk);
      @(negedge clk);
      bus_valid = 0;
      chk("R12 rd_valid", 32'(rd_valid), 32'd1);
      d = rd_data;
   endtask

   task automatic set_sel(logic [31:0] v);
      bus_wr(4'h0, v);
      msel = v;
   endtask

   task automatic check_flags(string req);
      logic [31:0] d;
      bus_rd(4'h4, d);
      chk(req, d, exp_flags());
   endtask

   task automatic check_data(string req);
      logic [31:0] d;
      bus_rd(4'h8, d);
      chk(req, d, msel);
   endtask

   task automatic ack_write(logic [31:0] d);
      bus_wr(4'h4, d);
      if (d[1] && msel < NS) mpend[msel[SW-1:0]] = 0;
   endtask

   task automatic plug(int slot, bit hot);
      @(negedge clk);
      plug_stb = 1; plug_slot = SW'(slot); plug_hot = hot;
      @(negedge clk);
      plug_stb = 0;
      chk("R5 irq after plug", 32'(evt_irq), 32'(hot));
      mpres[slot] = 1;
      if (hot) mpend[slot] = 1;
      @(negedge clk);
      chk("R5 irq one cycle", 32'(evt_irq), 32'd0);
   endtask

   task automatic run_cmd(logic [7:0] code);
      int exp_len = 0, n = 0;
      int hit = -1;
      int st;
      if (code == 0) begin
         st = (msel < NS) ? int'(msel) : 0;
         exp_len = NS;
         for (int k = 0; k < NS; k++) begin
            if (hit < 0 && mpend[(st + k) % NS]) begin
               hit = (st + k) % NS;
               exp_len = k + 1;
            end
         end
      end
      bus_wr(4'h5, {24'd0, code});
      while (scan_busy) begin
         chk("R8 ready low while busy", 32'(bus_ready), 32'd0);
         n++;
         @(negedge clk);
      end
      chk(code == 0 ? "R8 search length" : "R9 no search for bad code", n, exp_len);
      if (hit >= 0) msel = hit;
      check_data(code == 0 ? (hit >= 0 ? "R6 selector after hit" : "R7 selector after miss")
                           : "R9 command kept");
   endtask

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NS; i++) begin mpres[i] = 0; mpend[i] = 0; end
      msel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(scan_busy), 0);
      chk("R1 ready", 32'(bus_ready), 1);
      chk("R1 irq", 32'(evt_irq), 0);
      check_data("R1 selector zero");
      check_flags("R1 slot0 empty");

      // R5 cold and hot plugs
      plug(2, 0);
      set_sel(2);
      check_flags("R5 cold plug present only");
      plug(5, 1);
      set_sel(5);
      check_flags("R5 hot plug pending");
      // R4 writes that must not clear
      ack_write(32'h1);
      check_flags("R4 bit0 write no effect");
      ack_write(32'hFD);
      check_flags("R4 bit1 zero no effect");
      ack_write(32'h2);
      check_flags("R4 ack clears");
      // R3 / R4 out-of-range selector
      plug(3, 1);
      set_sel(32'd9);
      check_flags("R3 out of range reads zero");
      ack_write(32'h2);
      check_data("R2 selector 9");
      set_sel(3);
      check_flags("R4 out-of-range ack ignored");
      set_sel(32'hDEAD_BEEF);
      check_data("R2 full-width selector");

      // R6 / R7 / R8 searches
      set_sel(3); ack_write(2);
      plug(1, 1); plug(6, 1);
      set_sel(6);  run_cmd(0);
      set_sel(7);  run_cmd(0);
      set_sel(20); run_cmd(0);
      set_sel(1); ack_write(2); set_sel(6); ack_write(2);
      set_sel(4);  run_cmd(0);

      // R9 bad codes
      set_sel(2);
      run_cmd(8'd1);
      run_cmd(8'hFF);

      // R10 unmapped offsets and write-only registers
      foreach (d[i]) begin end
      for (int a = 0; a < 16; a++) begin
         if (a != 4 && a != 8) begin
            bus_rd(4'(a), d);
            chk("R10 unmapped read zero", d, 0);
         end
      end
      bus_wr(4'h8, 32'h5);
      bus_wr(4'h3, 32'hFF);
      bus_wr(4'hC, 32'h2);
      check_data("R10 writes ignored");

      // R11 same-cycle hot plug and ack on one slot
      set_sel(4);
      plug(4, 1);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = 4'h4; bus_wdata = 32'h2;
      plug_stb = 1; plug_slot = 3'd4; plug_hot = 1;
      @(negedge clk);
      bus_valid = 0; bus_write = 0; plug_stb = 0;
      check_flags("R11 plug wins over ack");

      // random phase
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 9);
         case (op)
            0, 1: plug($urandom_range(0, NS-1), 1'($urandom_range(0, 1)));
            2:    set_sel(($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, NS+1)));
            3:    ack_write($urandom());
            4, 5: check_flags("R3 random flags");
            6:    check_data("R2 random data");
            default: run_cmd(($urandom_range(0, 3) == 0) ? 8'($urandom_range(1, 255)) : 8'd0);
         endcase
      end

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule